// File: doc/BRIEF.md
# Serial Command Interface for a Dual Digital Potentiometer

This block is the control front end of a two-channel digital potentiometer. A host sends it 8-bit command words over a four-wire SPI-style link. The wires are an active-low select, a serial clock, serial data in and serial data out. The block holds two 5-bit wiper position registers, a 4-bit mute register and a 4-bit zero-crossing enable register, and it drives all four to the analog side as parallel outputs. It also raises a flag that asks the analog side to power down.

Each word is a 3-bit opcode followed by five data bits. Most opcodes write a register. Some opcodes do nothing. One opcode selects a readback, with the register chosen by the data pattern. The last opcode asks for power-down. The serial lines are oversampled by the system clock, so all state lives in a single synchronous domain.

Readback is deferred by one frame. A readback command takes a snapshot of the chosen register when its frame closes. The snapshot is then shifted out on the data-out line during the next frame, while that frame's own command is still being received.

Top module: `dpot_spi_ctrl`

## Requirements
- R1: After a synchronous reset both wipers read 00000, the mute and zero-crossing registers read 0000, the power-down flag is low and serial out is low.
- R2: Bits are taken on rising serial-clock edges, MSB first. The first three bits form the opcode and the last five form the data D4..D0. A command executes only when select rises after exactly 8 rising edges.
- R3: A frame with fewer or more than 8 rising edges is discarded. Serial-clock edges while select is high have no effect.
- R4: Opcode 000 loads D4..D0 into wiper 0. Opcode 010 loads D4..D0 into wiper 1.
- R5: Opcodes 001 and 011 change no register and leave the power-down flag as it is.
- R6: Opcode 100 loads D4..D1 into the mute register. Opcode 101 loads D4..D1 into the zero-crossing register. D0 is ignored for both.
- R7: Opcode 110 selects a readback by its data field: 00000 for wiper 0, 00010 for wiper 1, 00100 for mute and 00101 for zero-crossing. The 5-bit value is sent MSB first during the next frame. A 4-bit register is sent with a leading 0. The first bit is valid from the fall of select, and the output advances after each falling serial-clock edge. Bits after the fifth are 0, and a frame with no readback pending sends all zeros.
- R8: Opcode 110 with any other data field changes no register and arms no readback.
- R9: Opcode 111 with D4=0 sets the power-down flag only when the zero-crossing register is nonzero. With a zero register, or with D4=1, it has no effect.
- R10: The power-down flag stays set until reset or until a later write command executes (opcode 000, 010, 100 or 101).
- R11: Serial out is low whenever select is high.
- R12: The readback value is the register content at the close of the readback command's frame. A write to that register carried by the next frame does not alter the bits sent out in that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst | input | 1 | Synchronous active-high reset |
| ser_sel_n | input | 1 | Active-low frame select |
| ser_clk | input | 1 | Serial clock from the host |
| ser_in | input | 1 | Serial command data, MSB first |
| ser_out | output | 1 | Serial readback data |
| wiper0 | output | 5 | Channel 0 wiper position |
| wiper1 | output | 5 | Channel 1 wiper position |
| mute_bits | output | 4 | Mute register |
| zc_enable | output | 4 | Zero-crossing enable register |
| pwrdn_req | output | 1 | Power-down request flag |

## Verification
Two functions overlap in time: the shift-out of a readback armed by the previous frame, and the reception and execution of the current frame's command. The bench arms a readback of wiper 0. It then sends a frame that writes a new value to wiper 0 and captures serial out at every rising serial-clock edge of that frame. The captured bits must equal the old wiper value padded with three zeros, and wiper 0 must hold the new value once select rises. A second check chains readback commands back to back, so that each frame both sends the previous snapshot and arms the next one.

// File: rtl/dpot_pkg.sv
package dpot_pkg;

    localparam int OP_W   = 3;
    localparam int DATA_W = 5;
    localparam int CTRL_W = 4;
    localparam int WORD_W = OP_W + DATA_W;

    localparam logic [DATA_W-1:0] RB_CODE_W0   = 5'b00000;
    localparam logic [DATA_W-1:0] RB_CODE_W1   = 5'b00010;
    localparam logic [DATA_W-1:0] RB_CODE_MUTE = 5'b00100;
    localparam logic [DATA_W-1:0] RB_CODE_ZC   = 5'b00101;

    typedef enum logic [OP_W-1:0] {
        OP_WIPER0 = 3'b000,
        OP_IDLE1  = 3'b001,
        OP_WIPER1 = 3'b010,
        OP_IDLE3  = 3'b011,
        OP_MUTE   = 3'b100,
        OP_ZCROSS = 3'b101,
        OP_READ   = 3'b110,
        OP_PWRDN  = 3'b111
    } dpot_op_e;

    typedef enum logic [2:0] {
        RB_NONE, RB_W0, RB_W1, RB_MUTE, RB_ZC
    } rb_sel_e;

    typedef struct packed {
        logic              wr_w0;
        logic              wr_w1;
        logic              wr_mute;
        logic              wr_zc;
        logic              pwrdn;
        rb_sel_e           rb;
        logic [DATA_W-1:0] data;
    } dpot_act_t;

    function automatic dpot_act_t dpot_decode(input logic [WORD_W-1:0] w);
        dpot_act_t a;
        a      = '0;
        a.rb   = RB_NONE;
        a.data = w[DATA_W-1:0];
        case (dpot_op_e'(w[WORD_W-1 -: OP_W]))
            OP_WIPER0: a.wr_w0   = 1'b1;
            OP_WIPER1: a.wr_w1   = 1'b1;
            OP_MUTE:   a.wr_mute = 1'b1;
            OP_ZCROSS: a.wr_zc   = 1'b1;
            OP_READ: begin
                case (w[DATA_W-1:0])
                    RB_CODE_W0:   a.rb = RB_W0;
                    RB_CODE_W1:   a.rb = RB_W1;
                    RB_CODE_MUTE: a.rb = RB_MUTE;
                    RB_CODE_ZC:   a.rb = RB_ZC;
                    default:      a.rb = RB_NONE;
                endcase
            end
            OP_PWRDN:  a.pwrdn = ~w[DATA_W-1];
            default:   a = a;
        endcase
        return a;
    endfunction

endpackage

// File: rtl/dpot_spi_shift.sv
module dpot_spi_shift #(
    parameter int WORD_W = 8,
    parameter int OUT_W  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_n,
    input  logic              sclk,
    input  logic              sdi,
    input  logic              rb_pend,
    input  logic [OUT_W-1:0]  rb_val,
    output logic [WORD_W-1:0] word,
    output logic              frame_ok,
    output logic              sel_fall,
    output logic              sdo
);
    localparam int CNT_MAX = WORD_W + 1;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    logic             sel_q, sel_d, sclk_q, sclk_d, sdi_q;
    logic [CNT_W-1:0] cnt;
    logic [WORD_W-1:0] shreg;
    logic [OUT_W-1:0]  out_sr;
    logic             rise, fall, sel_rise;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q  <= 1'b1;
            sel_d  <= 1'b1;
            sclk_q <= 1'b0;
            sclk_d <= 1'b0;
            sdi_q  <= 1'b0;
        end else begin
            sel_q  <= sel_n;
            sel_d  <= sel_q;
            sclk_q <= sclk;
            sclk_d <= sclk_q;
            sdi_q  <= sdi;
        end
    end

    assign rise     = sclk_q & ~sclk_d;
    assign fall     = ~sclk_q & sclk_d;
    assign sel_rise = sel_q & ~sel_d;
    assign sel_fall = ~sel_q & sel_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            shreg <= '0;
        end else if (sel_q) begin
            cnt <= '0;
        end else if (rise) begin
            shreg <= {shreg[WORD_W-2:0], sdi_q};
            if (cnt != CNT_W'(CNT_MAX)) cnt <= cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_sr <= '0;
        end else if (sel_fall) begin
            out_sr <= rb_pend ? rb_val : '0;
        end else if (!sel_q && fall) begin
            out_sr <= {out_sr[OUT_W-2:0], 1'b0};
        end
    end

    assign frame_ok = sel_rise && (cnt == CNT_W'(WORD_W));
    assign word     = shreg;
    assign sdo      = sel_q ? 1'b0 : out_sr[OUT_W-1];

    a_r3_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(CNT_MAX));
    a_r2_single_exec: assert property (@(posedge clk) disable iff (rst)
        frame_ok |=> !frame_ok);
    a_r3_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (sel_q && $past(sel_q)) |-> $stable(shreg));
endmodule

// File: rtl/dpot_cmd_decode.sv
module dpot_cmd_decode
    import dpot_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output dpot_act_t         act
);
    always_comb act = dpot_decode(word);
endmodule

// File: rtl/dpot_regs.sv
module dpot_regs
    import dpot_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int CW = CTRL_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          exec,
    input  dpot_act_t     act,
    input  logic          sel_fall,
    output logic [DW-1:0] wiper0,
    output logic [DW-1:0] wiper1,
    output logic [CW-1:0] mute_bits,
    output logic [CW-1:0] zc_enable,
    output logic          pwrdn_req,
    output logic          rb_pend,
    output logic [DW-1:0] rb_val
);
    localparam int PAD = DW - CW;

    logic [DW-1:0] rb_next;
    logic          any_wr;

    assign any_wr = act.wr_w0 | act.wr_w1 | act.wr_mute | act.wr_zc;

    always_comb begin
        case (act.rb)
            RB_W0:   rb_next = wiper0;
            RB_W1:   rb_next = wiper1;
            RB_MUTE: rb_next = {{PAD{1'b0}}, mute_bits};
            RB_ZC:   rb_next = {{PAD{1'b0}}, zc_enable};
            default: rb_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wiper0    <= '0;
            wiper1    <= '0;
            mute_bits <= '0;
            zc_enable <= '0;
            pwrdn_req <= 1'b0;
            rb_pend   <= 1'b0;
            rb_val    <= '0;
        end else if (exec) begin
            if (act.wr_w0)   wiper0    <= act.data;
            if (act.wr_w1)   wiper1    <= act.data;
            if (act.wr_mute) mute_bits <= act.data[DW-1 -: CW];
            if (act.wr_zc)   zc_enable <= act.data[DW-1 -: CW];
            if (act.pwrdn && zc_enable != '0) pwrdn_req <= 1'b1;
            else if (any_wr)                  pwrdn_req <= 1'b0;
            if (act.rb != RB_NONE) begin
                rb_pend <= 1'b1;
                rb_val  <= rb_next;
            end
        end else if (sel_fall) begin
            rb_pend <= 1'b0;
        end
    end

    a_r4_wiper_hold: assert property (@(posedge clk) disable iff (rst)
        !exec |=> ($stable(wiper0) && $stable(wiper1)));
    a_r6_mute_load: assert property (@(posedge clk) disable iff (rst)
        (exec && act.wr_mute) |=> mute_bits == $past(act.data[DW-1 -: CW]));
    a_r9_pd_needs_zc: assert property (@(posedge clk) disable iff (rst)
        $rose(pwrdn_req) |-> ($past(exec) && $past(zc_enable) != '0));
    a_r8_read_quiet: assert property (@(posedge clk) disable iff (rst)
        (exec && !any_wr && !act.pwrdn) |=>
        ($stable(wiper0) && $stable(wiper1) && $stable(mute_bits) && $stable(zc_enable)));
endmodule

// File: rtl/dpot_spi_ctrl.sv
module dpot_spi_ctrl
    import dpot_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_sel_n,
    input  logic              ser_clk,
    input  logic              ser_in,
    output logic              ser_out,
    output logic [DATA_W-1:0] wiper0,
    output logic [DATA_W-1:0] wiper1,
    output logic [CTRL_W-1:0] mute_bits,
    output logic [CTRL_W-1:0] zc_enable,
    output logic              pwrdn_req
);
    logic [WORD_W-1:0] word;
    logic              frame_ok, sel_fall, rb_pend;
    logic [DATA_W-1:0] rb_val;
    dpot_act_t         act;

    dpot_spi_shift #(.WORD_W(WORD_W), .OUT_W(DATA_W)) u_shift (
        .clk(clk), .rst(rst), .sel_n(ser_sel_n), .sclk(ser_clk), .sdi(ser_in),
        .rb_pend(rb_pend), .rb_val(rb_val), .word(word), .frame_ok(frame_ok),
        .sel_fall(sel_fall), .sdo(ser_out)
    );

    dpot_cmd_decode u_dec (.word(word), .act(act));

    dpot_regs #(.DW(DATA_W), .CW(CTRL_W)) u_regs (
        .clk(clk), .rst(rst), .exec(frame_ok), .act(act), .sel_fall(sel_fall),
        .wiper0(wiper0), .wiper1(wiper1), .mute_bits(mute_bits),
        .zc_enable(zc_enable), .pwrdn_req(pwrdn_req),
        .rb_pend(rb_pend), .rb_val(rb_val)
    );

    a_r11_out_idle: assert property (@(posedge clk) disable iff (rst)
        ($past(ser_sel_n) && ser_sel_n) |-> !ser_out);
endmodule

// File: tb/dpot_spi_ctrl_bench.sv
`timescale 1ns/1ps
module dpot_spi_ctrl_bench;
    logic       clk = 1'b0, rst = 1'b1, sel_n = 1'b1, sclk = 1'b0, din = 1'b0;
    logic       dout, pd;
    logic [4:0] w0, w1;
    logic [3:0] mu, zc;
    int checks = 0, errors = 0, cycles = 0;
    logic [7:0] got;

    always #2 clk = ~clk;

    dpot_spi_ctrl u_dpot_spi_ctrl (
        .clk(clk), .rst(rst), .ser_sel_n(sel_n), .ser_clk(sclk), .ser_in(din),
        .ser_out(dout), .wiper0(w0), .wiper1(w1), .mute_bits(mu),
        .zc_enable(zc), .pwrdn_req(pd)
    );

    // word, wiper0, wiper1, mute, zero-crossing, power-down after the frame
    localparam logic [26:0] VEC [12] = '{
        {8'b00010110, 5'b10110, 5'b00000, 4'b0000, 4'b0000, 1'b0},
        {8'b01001011, 5'b10110, 5'b01011, 4'b0000, 4'b0000, 1'b0},
        {8'b00111111, 5'b10110, 5'b01011, 4'b0000, 4'b0000, 1'b0},
        {8'b01100000, 5'b10110, 5'b01011, 4'b0000, 4'b0000, 1'b0},
        {8'b10010101, 5'b10110, 5'b01011, 4'b1010, 4'b0000, 1'b0},
        {8'b10101100, 5'b10110, 5'b01011, 4'b1010, 4'b0110, 1'b0},
        {8'b10001010, 5'b10110, 5'b01011, 4'b0101, 4'b0110, 1'b0},
        {8'b11110000, 5'b10110, 5'b01011, 4'b0101, 4'b0110, 1'b0},
        {8'b11101111, 5'b10110, 5'b01011, 4'b0101, 4'b0110, 1'b1},
        {8'b00100000, 5'b10110, 5'b01011, 4'b0101, 4'b0110, 1'b1},
        {8'b00011111, 5'b11111, 5'b01011, 4'b0101, 4'b0110, 1'b0},
        {8'b00000000, 5'b00000, 5'b01011, 4'b0101, 4'b0110, 1'b0}
    };

    function automatic string vtag(input int i);
        case (i)
            0, 1, 10, 11: return "R4";
            2, 3:         return "R5";
            4, 5, 6:      return "R6";
            7, 8:         return "R9";
            default:      return "R10";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_regs(input string tag, input logic [4:0] e0, input logic [4:0] e1,
                            input logic [3:0] em, input logic [3:0] ez, input logic ep);
        chk({tag, " wiper0"}, 32'(w0), 32'(e0));
        chk({tag, " wiper1"}, 32'(w1), 32'(e1));
        chk({tag, " mute"},   32'(mu), 32'(em));
        chk({tag, " zc"},     32'(zc), 32'(ez));
        chk({tag, " pwrdn"},  32'(pd), 32'(ep));
    endtask

    // send nbits of w MSB first, capture serial out before each rising edge
    task automatic frame(input logic [7:0] w, input int nbits, output logic [7:0] cap);
        cap = '0;
        @(negedge clk) sel_n = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            din = (i < 8) ? w[7-i] : 1'b0;
            repeat (4) @(negedge clk);
            if (i < 8) cap[7-i] = dout;
            sclk = 1'b1;
            repeat (4) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (4) @(negedge clk);
        sel_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected<150000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk_regs("R1 reset", 5'd0, 5'd0, 4'd0, 4'd0, 1'b0);
        chk("R1 dout", 32'(dout), 32'd0);

        // R2: table walk, each frame 8 bits MSB first
        for (int i = 0; i < 12; i++) begin
            frame(VEC[i][26:19], 8, got);
            chk_regs({vtag(i), "/R2 vec"}, VEC[i][18:14], VEC[i][13:9],
                     VEC[i][8:5], VEC[i][4:1], VEC[i][0]);
        end
        // state: w0=0 w1=01011 mute=0101 zc=0110 pd=0

        // R7: readback chain wiper1 -> mute -> zc
        frame(8'b110_00010, 8, got);
        chk("R11 dout idle with pending", 32'(dout), 32'd0);
        frame(8'b110_00100, 8, got);
        chk("R7 readback wiper1", 32'(got), 32'b01011_000);
        frame(8'b110_00101, 8, got);
        chk("R7 readback mute", 32'(got), 32'b00101_000);
        frame(8'b001_00000, 8, got);
        chk("R7 readback zc", 32'(got), 32'b00110_000);
        frame(8'b001_00000, 8, got);
        chk("R7 no pending", 32'(got), 32'd0);

        // R12: snapshot versus write in the shifting-out frame
        frame(8'b000_10001, 8, got);
        frame(8'b110_00000, 8, got);
        frame(8'b000_00111, 8, got);
        chk("R12 old value out", 32'(got), 32'b10001_000);
        chk("R12 new value", 32'(w0), 32'b00111);

        // R8: reserved readback codes
        frame(8'b110_00001, 8, got);
        frame(8'b110_00011, 8, got);
        chk("R8 no readback", 32'(got), 32'd0);
        frame(8'b110_11111, 8, got);
        chk("R8 no readback 2", 32'(got), 32'd0);
        frame(8'b001_00000, 8, got);
        chk("R8 no readback 3", 32'(got), 32'd0);
        chk_regs("R8 regs", 5'b00111, 5'b01011, 4'b0101, 4'b0110, 1'b0);

        // R3: short and long frames, clocks while deselected
        frame(8'b010_11100, 7, got);
        chk_regs("R3 short", 5'b00111, 5'b01011, 4'b0101, 4'b0110, 1'b0);
        frame(8'b010_11100, 9, got);
        chk_regs("R3 long", 5'b00111, 5'b01011, 4'b0101, 4'b0110, 1'b0);
        din = 1'b1;
        for (int k = 0; k < 8; k++) begin
            repeat (3) @(negedge clk) sclk = 1'b1;
            repeat (3) @(negedge clk) sclk = 1'b0;
        end
        din = 1'b0;
        repeat (6) @(negedge clk);
        chk_regs("R3 deselected clocks", 5'b00111, 5'b01011, 4'b0101, 4'b0110, 1'b0);
        frame(8'b010_11100, 8, got);
        chk("R3 R2 frame after idle", 32'(w1), 32'b11100);

        // R9: power-down with zero-crossing cleared does nothing
        frame(8'b101_0000_1, 8, got);
        frame(8'b111_00000, 8, got);
        chk("R9 zc off", 32'(pd), 32'd0);
        frame(8'b101_0001_0, 8, got);
        frame(8'b111_01010, 8, got);
        chk("R9 zc on", 32'(pd), 32'd1);
        frame(8'b110_00000, 8, got);
        chk("R10 read keeps pd", 32'(pd), 32'd1);
        frame(8'b100_1111_1, 8, got);
        chk("R10 write clears pd", 32'(pd), 32'd0);
        chk("R6 mute all ones", 32'(mu), 32'hF);

        // R1: mid-run reset
        frame(8'b111_00000, 8, got);
        @(negedge clk) rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk_regs("R1 mid reset", 5'd0, 5'd0, 4'd0, 4'd0, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule